// File: doc/BRIEF.md
# Bus Hold Release Arbiter

This block sits beside the CPU-side bus sequencer and decides the moment at which the bus may be handed to an external master. The external master asks through an active-low request line, which the block first passes through a two-flop synchronizer. The sequencer reports each transaction as it starts: its kind (single, double word, or atomic load-store), its direction, and its port width. It also reports each beat as that beat completes. From this the block works out which beat completions are legal release points. At the first legal point after the request is seen, it drives an active-low grant.

Whenever a release is due or the bus is granted, the block asks the sequencer to hold off new bus cycles. That hold stays on for one clock after the grant ends, so the sequencer can resume on the clock after that. While the grant is held and strobe-select mode is low, any address strobe started on the CPU side is blocked.

Top module: `bus_release_arbiter`

## Requirements
- R1: During and directly after reset, `bus_grant_n` is 1, `seq_hold` is 0 and `as_out_n` follows `cpu_as_n`.
- R2: With no transaction in progress, a low level on `bus_req_n` works as follows. After the second rising edge that samples it low, `seq_hold` is 1 while `bus_grant_n` is still 1. After the third such edge, `bus_grant_n` is 0.
- R3: An atomic transaction (`xfer_kind`=2) gives no grant before all of its beats have completed. That is 2×B beats, where B is the number of beats per word: 4, 2 and 1 for `xfer_width` values 0 (8-bit), 1 (16-bit) and 2 (32-bit).
- R4: For a double-word transaction (`xfer_kind`=1) that may split, a request seen before the B-th beat completes is granted at the end of that B-th beat. A double-word load may always split. A double-word store may split only when `xfer_width`=2.
- R5: For a double-word transaction, a request first seen after the first word is granted only when all 2×B beats have completed.
- R6: A store (`xfer_store`=1) through an 8- or 16-bit port is never released before its whole operand has been moved. A double-word store there takes 2×B beats, and a single store (`xfer_kind`=0) takes B beats.
- R7: A load through an 8- or 16-bit port is released after one complete word, which is B beats.
- R8: Once the synchronized request goes inactive, `bus_grant_n` returns to 1 one clock later. `seq_hold` stays 1 for exactly one clock beyond that and then drops.
- R9: While `bus_grant_n` is 0 and `strobe_sel` is 0, `as_out_n` is 1 whatever `cpu_as_n` does. With `strobe_sel` at 1, `as_out_n` follows `cpu_as_n`.
- R10: While `seq_hold` is 1, no beat completes and the grant is not lost. After a grant, the held transaction resumes and completes its remaining beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req_n | input | 1 | Asynchronous bus request from the external master, active low |
| xfer_start | input | 1 | One-clock pulse when the sequencer begins a transaction |
| xfer_kind | input | 2 | Transaction kind: 0 single, 1 double word, 2 atomic load-store |
| xfer_store | input | 1 | 1 for a store, 0 for a load |
| xfer_width | input | 2 | Port width: 0 8-bit, 1 16-bit, 2 32-bit |
| beat_done | input | 1 | One-clock pulse at each completed beat |
| strobe_sel | input | 1 | Strobe-select mode; 0 blocks local strobes during grant |
| cpu_as_n | input | 1 | Address strobe from the CPU side, active low |
| bus_grant_n | output | 1 | Bus grant to the external master, active low |
| seq_hold | output | 1 | Tells the sequencer to start no new bus cycle |
| as_out_n | output | 1 | Address strobe toward the bus, active low |

## Verification
The assertions take three things for granted about the inputs. `xfer_start` comes only while no transaction is open and `seq_hold` is low. `beat_done` comes only inside an open transaction and never while `seq_hold` is high. The attribute inputs are steady with the start pulse. The stimulus plays the role of a well-behaved sequencer: it opens one transaction at a time, issues a beat only in a cycle where `seq_hold` is low, and finishes the remaining beats before it starts the next transaction. Release points are placed by raising the request after a chosen number of beats and then waiting until the synchronizer has settled.

// File: rtl/brha_pkg.sv
// Shared encodings for the bus hold release arbiter.
// Assumes the sequencer uses these codes on its attribute inputs.
package brha_pkg;
    typedef enum logic [1:0] {
        XK_SINGLE = 2'd0,
        XK_DOUBLE = 2'd1,
        XK_ATOMIC = 2'd2
    } xfer_kind_e;

    typedef enum logic [1:0] {
        PW_8  = 2'd0,
        PW_16 = 2'd1,
        PW_32 = 2'd2
    } port_width_e;
endpackage

// File: rtl/brha_req_sync.sv
// Multi-flop synchronizer for the asynchronous active-low request.
// Output req_on is active high. Assumes the request is held long enough to be sampled.
module brha_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_async,
    output logic req_on
);
    logic [STAGES-1:0] chain;

    // shift the raw request through the flop chain; idle level is 1
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], req_n_async};
    end

    assign req_on = ~chain[STAGES-1];
endmodule

// File: rtl/brha_xfer_tracker.sv
// Tracks the open transaction: latches its attributes, counts beats and
// flags each beat completion that is a legal release point.
// Assumes start comes only when idle and beats only while a transaction is open.
module brha_xfer_tracker
    import brha_pkg::*;
#(
    parameter int BUS_BITS      = 32,
    parameter int MIN_PORT_BITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] kind,
    input  logic       store,
    input  logic [1:0] width,
    input  logic       beat_done,
    output logic       active,
    output logic       brk,
    output logic       is_atomic,
    output logic       narrow_store
);
    localparam int MAX_BPW = BUS_BITS / MIN_PORT_BITS;
    localparam int CNT_W   = $clog2(2 * MAX_BPW + 1);

    xfer_kind_e        kind_q;
    port_width_e       width_q;
    logic              store_q;
    logic [CNT_W-1:0]  cnt, nxt, bpw, total;
    logic              narrow, split_ok;

    // beats needed for one word at the latched port width
    always_comb begin
        case (width_q)
            PW_8:    bpw = CNT_W'(MAX_BPW);
            PW_16:   bpw = CNT_W'(MAX_BPW / 2);
            default: bpw = CNT_W'(1);
        endcase
    end

    // total beats and whether a word boundary may serve as release point
    always_comb begin
        narrow   = (width_q != PW_32);
        total    = (kind_q == XK_SINGLE) ? bpw : CNT_W'(bpw << 1);
        split_ok = (kind_q == XK_DOUBLE) && !(store_q && narrow);
        nxt      = cnt + CNT_W'(1);
        brk      = active && beat_done &&
                   ((nxt == total) || (split_ok && (nxt == bpw)));
    end

    // open, count and close the transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            kind_q  <= XK_SINGLE;
            width_q <= PW_32;
            store_q <= 1'b0;
        end else if (start) begin
            active  <= 1'b1;
            cnt     <= '0;
            kind_q  <= (kind == 2'd3) ? XK_SINGLE : xfer_kind_e'(kind);
            width_q <= (width == 2'd3) ? PW_32 : port_width_e'(width);
            store_q <= store;
        end else if (active && beat_done) begin
            cnt <= nxt;
            if (nxt == total) active <= 1'b0;
        end
    end

    assign is_atomic    = (kind_q == XK_ATOMIC);
    assign narrow_store = store_q && narrow;

    // R10
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < total));
endmodule

// File: rtl/brha_release_ctrl.sv
// Grant and hold state machine. Releases when the request is seen and the
// bus is idle or at a release point; ends the grant one clock after the
// request drops and keeps the hold one clock longer.
module brha_release_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_on,
    input  logic active,
    input  logic brk,
    output logic granted,
    output logic hold
);
    logic tail_q, release_now;

    // a release is due this cycle
    assign release_now = req_on && !granted && !tail_q && (!active || brk);

    // grant and tail registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            granted <= 1'b0;
            tail_q  <= 1'b0;
        end else begin
            granted <= granted ? req_on : release_now;
            tail_q  <= granted && !req_on;
        end
    end

    assign hold = granted || tail_q || release_now;

    // R8
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        granted && !req_on |=> !granted);
    // R8
    tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(granted) |-> hold);
endmodule

// File: rtl/bus_release_arbiter.sv
// Top of the bus hold release arbiter. Joins synchronizer, transaction
// tracker and release control, and gates the local address strobe.
// Assumes the sequencer honours seq_hold and starts transactions only when idle.
module bus_release_arbiter #(
    parameter int BUS_BITS      = 32,
    parameter int MIN_PORT_BITS = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_req_n,
    input  logic       xfer_start,
    input  logic [1:0] xfer_kind,
    input  logic       xfer_store,
    input  logic [1:0] xfer_width,
    input  logic       beat_done,
    input  logic       strobe_sel,
    input  logic       cpu_as_n,
    output logic       bus_grant_n,
    output logic       seq_hold,
    output logic       as_out_n
);
    logic req_on, trk_active, trk_brk, trk_atomic, trk_nstore, granted;

    brha_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_n_async(bus_req_n), .req_on(req_on));

    brha_xfer_tracker #(.BUS_BITS(BUS_BITS), .MIN_PORT_BITS(MIN_PORT_BITS)) u_trk (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .kind(xfer_kind),
        .store(xfer_store), .width(xfer_width), .beat_done(beat_done),
        .active(trk_active), .brk(trk_brk), .is_atomic(trk_atomic),
        .narrow_store(trk_nstore));

    brha_release_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_on(req_on), .active(trk_active),
        .brk(trk_brk), .granted(granted), .hold(seq_hold));

    assign bus_grant_n = ~granted;

    // block local strobes while granted unless strobe-select mode is high
    assign as_out_n = cpu_as_n | (granted & ~strobe_sel);

    // R4
    grant_at_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_grant_n) |-> $past(!trk_active || trk_brk));
    // R3
    atomic_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_grant_n) |-> !(trk_active && trk_atomic));
    // R6
    narrow_store_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_grant_n) |-> !(trk_active && trk_nstore));
    // R10
    no_beat_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_grant_n && !beat_done |=> !$rose(bus_grant_n) || $past(!req_on));
endmodule

// File: tb/bus_release_arbiter_tb.sv
module bus_release_arbiter_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0, bus_req_n = 1, xfer_start = 0, xfer_store = 0;
    logic beat_done = 0, strobe_sel = 0, cpu_as_n = 1;
    logic [1:0] xfer_kind = 0, xfer_width = 2;
    logic bus_grant_n, seq_hold, as_out_n;
    int n_chk = 0, n_bad = 0;

    bus_release_arbiter u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int bpw_of(input int w);
        return (w == 0) ? 4 : (w == 1) ? 2 : 1;
    endfunction

    function automatic int total_of(input int k, input int w);
        return (k == 0) ? bpw_of(w) : 2 * bpw_of(w);
    endfunction

    // beats completed when the grant comes, request seen after req_at beats
    function automatic int exp_grant(input int k, input int st, input int w, input int req_at);
        bit split = (k == 1) && !(st == 1 && w != 2);
        if (split && req_at < bpw_of(w)) return bpw_of(w);
        return total_of(k, w);
    endfunction

    function automatic string tag_of(input int k, input int st, input int w);
        if (k == 2) return "R3";
        if (st == 1 && w != 2) return "R6";
        if (k == 1 && st == 0 && w != 2) return "R7";
        return (k == 1) ? "R4" : "R5";
    endfunction

    task automatic run_xfer(input int k, input int st, input int w, input int req_at);
        int total = total_of(k, w);
        int done = 0, got = -1, exp;
        string tg;
        @(negedge clk);
        xfer_kind = 2'(k); xfer_store = 1'(st); xfer_width = 2'(w); xfer_start = 1;
        @(negedge clk);
        xfer_start = 0;
        for (int c = 0; c < 400 && got < 0; c++) begin
            if (done == req_at && bus_req_n) begin
                bus_req_n = 0;
                repeat (3) @(negedge clk);
            end
            if (!bus_grant_n) got = done;
            else if (done < total && !seq_hold) begin
                beat_done = 1; @(negedge clk); beat_done = 0; done++;
            end else @(negedge clk);
        end
        exp = exp_grant(k, st, w, req_at);
        tg = (req_at >= bpw_of(w) && k == 1) ? "R5" : tag_of(k, st, w);
        chk(got == exp, tg, got, exp);
        // R9 strobe blocking while granted
        cpu_as_n = 0; strobe_sel = 0; #1;
        chk(as_out_n == 1, "R9", as_out_n, 1);
        strobe_sel = 1; #1;
        chk(as_out_n == 0, "R9", as_out_n, 0);
        cpu_as_n = 1; strobe_sel = 0;
        // R10 hold stays on while granted
        chk(seq_hold == 1, "R10", seq_hold, 1);
        // R8 release timing
        bus_req_n = 1;
        repeat (2) @(negedge clk);
        chk(bus_grant_n == 0, "R8", bus_grant_n, 0);
        @(negedge clk);
        chk(bus_grant_n == 1 && seq_hold == 1, "R8", {bus_grant_n, seq_hold}, 3);
        @(negedge clk);
        chk(seq_hold == 0, "R8", seq_hold, 0);
        // R10 resume and finish remaining beats
        while (done < total) begin
            if (!seq_hold) begin
                beat_done = 1; @(negedge clk); beat_done = 0; done++;
            end else @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk(bus_grant_n == 1 && seq_hold == 0, "R10", {bus_grant_n, seq_hold}, 2);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_grant_n == 1 && seq_hold == 0, "R1", {bus_grant_n, seq_hold}, 2);
        cpu_as_n = 0; #1;
        chk(as_out_n == 0, "R1", as_out_n, 0);
        cpu_as_n = 1;
        rst_n = 1;
        @(negedge clk);
        chk(bus_grant_n == 1 && seq_hold == 0, "R1", {bus_grant_n, seq_hold}, 2);

        // R2 idle grant timing
        bus_req_n = 0;
        repeat (2) @(negedge clk);
        chk(seq_hold == 1 && bus_grant_n == 1, "R2", {seq_hold, bus_grant_n}, 3);
        @(negedge clk);
        chk(bus_grant_n == 0, "R2", bus_grant_n, 0);
        bus_req_n = 1;
        repeat (4) @(negedge clk);
        chk(bus_grant_n == 1 && seq_hold == 0, "R8", {bus_grant_n, seq_hold}, 2);

        // directed corners
        run_xfer(2, 0, 0, 0);   // R3 atomic on 8-bit
        run_xfer(2, 1, 2, 1);   // R3 atomic on 32-bit
        run_xfer(1, 0, 2, 0);   // R4 double split after first word
        run_xfer(1, 0, 2, 1);   // R5 request in second word
        run_xfer(1, 1, 0, 0);   // R6 double store on 8-bit
        run_xfer(0, 1, 1, 0);   // R6 single store on 16-bit
        run_xfer(1, 0, 0, 1);   // R7 narrow load double
        run_xfer(1, 0, 1, 2);   // R5 narrow load, request after word

        // constrained random
        for (int i = 0; i < 40; i++) begin
            int k = $urandom_range(0, 2);
            int w = $urandom_range(0, 2);
            int st = $urandom_range(0, 1);
            run_xfer(k, st, w, $urandom_range(0, total_of(k, w)));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule